// File: doc/BRIEF.md
# Bus Occupancy Cycle Calculator

This block keeps track of when a shared memory bus will next be free. Each time a packet is granted onto the bus, the block works out how many bus cycles the transfer holds the bus. The count comes from the packet's class flags and its payload byte count. The block first brings its stored idle time up to the current time on a bus-cycle boundary, then moves that time forward by the occupancy span. When the time input reaches the stored idle time, a one-cycle pulse tells the retry logic that the bus can be offered again.

Time is given in ticks by a free-running counter input. One bus cycle is `CLK_TICKS` ticks long. The bus moves `BEAT_BYTES` bytes per cycle, and `BEAT_BYTES` must be a power of two, so the round-up division is a shift plus a test of the remainder bits. The time input starts at zero when reset is released and rises by no more than one bus period per clock. The block follows the current cycle boundary one period at a time and never divides the time.

Top module: `occ_bus_tracker`

## Requirements
- R1: After reset, `next_idle_o` is 0, `busy_o` is low and `free_o` is low.
- R2: A granted packet with `is_req_i` set holds the bus for exactly one cycle, whatever the data flag and size.
- R3: A granted packet without `is_req_i` but with `has_data_i` set holds the bus for ceil(`size_i` / `BEAT_BYTES`) cycles.
- R4: A data packet with a byte count of zero holds the bus for one cycle, never zero.
- R5: A granted response with neither the request flag nor the data flag holds the bus for one cycle. A grant with none of the three flags adds no cycles but still applies the alignment of R6.
- R6: If the stored idle time is below the time input at a grant, it is first raised to the smallest multiple of `CLK_TICKS` that is not below the time input. A grant landing exactly on a boundary starts on that boundary. A stored idle time at or above the time input is kept.
- R7: After a grant, the idle time is the aligned value plus the occupancy cycles times `CLK_TICKS`. It changes only in the cycle after a grant.
- R8: `busy_o` is high exactly when the time input is below `next_idle_o`.
- R9: After a grant, `free_o` pulses for one cycle in the first cycle where the time input is at or past the idle time and no grant is being presented. A further grant made before the pulse moves it to the new idle time, so only one pulse is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grant_i | input | 1 | A packet is placed on the bus this cycle |
| is_req_i | input | 1 | Packet is a request (address cycle only) |
| is_resp_i | input | 1 | Packet is a response |
| has_data_i | input | 1 | Packet carries a data payload |
| size_i | input | SIZE_W | Payload length in bytes |
| now_i | input | TIME_W | Current time in ticks, free running |
| busy_o | output | 1 | Bus still occupied at the current time |
| next_idle_o | output | TIME_W | Time at which the bus becomes idle |
| free_o | output | 1 | One-cycle pulse when the bus becomes available |

## Verification
A wrong occupancy count or a wrong alignment shows up on `next_idle_o` in the cycle after the grant, before any later effect. A stale boundary tracker appears as an idle time off the period grid. A pending flag that is not cleared or not moved shows up later, once the time input crosses the idle time: as a missing, doubled or early `free_o` pulse, and in `busy_o` dropping in the wrong cycle. Both outputs are therefore compared on every cycle against a model, and grants are placed on a boundary, just after one, and in the very cycle a pulse would fire.

// File: rtl/occ_pkg.sv
package occ_pkg;

   // Packet classes that set the occupancy length.
   typedef enum logic [1:0] {
      PK_NONE = 2'd0,   // no flag: alignment only
      PK_ADDR = 2'd1,   // request: one address cycle
      PK_DATA = 2'd2,   // payload: one cycle per beat
      PK_ACK  = 2'd3    // dataless response: one cycle
   } pk_class_e;

   // The request flag wins over the data flag; the data flag wins over the response flag.
   function automatic pk_class_e pk_classify(input logic req, input logic resp,
                                             input logic dat);
      pk_class_e c;
      if (req)       c = PK_ADDR;
      else if (dat)  c = PK_DATA;
      else if (resp) c = PK_ACK;
      else           c = PK_NONE;
      return c;
   endfunction

endpackage

// File: rtl/occ_len_calc.sv
module occ_len_calc
   import occ_pkg::*;
#(
   parameter int SIZE_W     = 16,
   parameter int BEAT_BYTES = 64
) (
   input  logic              is_req_i,
   input  logic              is_resp_i,
   input  logic              has_data_i,
   input  logic [SIZE_W-1:0] size_i,
   output logic [SIZE_W-1:0] cycles_o
);
   localparam int SH = (BEAT_BYTES > 1) ? $clog2(BEAT_BYTES) : 0;

   logic [SIZE_W-1:0] beats;
   pk_class_e         cls;

   generate
      if (BEAT_BYTES < 1 || (BEAT_BYTES & (BEAT_BYTES - 1)) != 0) begin : g_bad_width
         $error("BEAT_BYTES must be a non-zero power of two");
      end
      if (SH >= SIZE_W) begin : g_bad_size
         $error("SIZE_W must be wider than log2(BEAT_BYTES)");
      end
      if (SH == 0) begin : g_byte_bus
         assign beats = size_i;
      end else begin : g_wide_bus
         logic [SIZE_W-1:0] whole;
         logic              part;
         assign whole = size_i >> SH;
         assign part  = |size_i[SH-1:0];
         assign beats = whole + {{(SIZE_W-1){1'b0}}, part};
      end
   endgenerate

   assign cls = pk_classify(is_req_i, is_resp_i, has_data_i);

   always_comb begin
      unique case (cls)
         PK_ADDR: cycles_o = SIZE_W'(1);
         PK_ACK:  cycles_o = SIZE_W'(1);
         PK_DATA: cycles_o = (beats == '0) ? SIZE_W'(1) : beats;
         default: cycles_o = '0;
      endcase
   end

endmodule

// File: rtl/occ_align.sv
module occ_align #(
   parameter int TIME_W    = 32,
   parameter int CLK_TICKS = 1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] now_i,
   input  logic [TIME_W-1:0] idle_i,
   output logic [TIME_W-1:0] base_o
);
   localparam logic [TIME_W-1:0] PER = TIME_W'(CLK_TICKS);

   generate
      if (CLK_TICKS < 1) begin : g_bad_period
         $error("CLK_TICKS must be non-zero");
      end
   endgenerate

   // Smallest period multiple not below now_i, followed one step per clock.
   logic [TIME_W-1:0] bnd_q;
   logic [TIME_W-1:0] ceil_now;

   assign ceil_now = (now_i > bnd_q) ? bnd_q + PER : bnd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) bnd_q <= '0;
      else        bnd_q <= ceil_now;
   end

   assign base_o = (idle_i >= now_i) ? idle_i : ceil_now;

   assert_base_not_past_R6: assert property (@(posedge clk) disable iff (!rst_n)
      base_o >= now_i)
      else $error("aligned base below current time");

endmodule

// File: rtl/occ_free_sched.sv
module occ_free_sched (
   input  logic clk,
   input  logic rst_n,
   input  logic grant_i,
   input  logic busy_i,
   output logic free_o
);
   logic pend_q;

   assign free_o = pend_q & ~busy_i & ~grant_i;

   always_ff @(posedge clk) begin
      if (!rst_n)       pend_q <= 1'b0;
      else if (grant_i) pend_q <= 1'b1;
      else if (free_o)  pend_q <= 1'b0;
   end

   assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      free_o |=> !free_o)
      else $error("bus-free pulse longer than one cycle");

endmodule

// File: rtl/occ_bus_tracker.sv
module occ_bus_tracker #(
   parameter int TIME_W     = 32,
   parameter int SIZE_W     = 16,
   parameter int BEAT_BYTES = 64,
   parameter int CLK_TICKS  = 1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              grant_i,
   input  logic              is_req_i,
   input  logic              is_resp_i,
   input  logic              has_data_i,
   input  logic [SIZE_W-1:0] size_i,
   input  logic [TIME_W-1:0] now_i,
   output logic              busy_o,
   output logic [TIME_W-1:0] next_idle_o,
   output logic              free_o
);
   localparam logic [TIME_W-1:0] PER = TIME_W'(CLK_TICKS);

   logic [SIZE_W-1:0] cycles;
   logic [TIME_W-1:0] span;
   logic [TIME_W-1:0] base;
   logic [TIME_W-1:0] idle_q;

   occ_len_calc #(.SIZE_W(SIZE_W), .BEAT_BYTES(BEAT_BYTES)) u_len (
      .is_req_i  (is_req_i),
      .is_resp_i (is_resp_i),
      .has_data_i(has_data_i),
      .size_i    (size_i),
      .cycles_o  (cycles)
   );

   occ_align #(.TIME_W(TIME_W), .CLK_TICKS(CLK_TICKS)) u_align (
      .clk   (clk),
      .rst_n (rst_n),
      .now_i (now_i),
      .idle_i(idle_q),
      .base_o(base)
   );

   assign span = TIME_W'(cycles) * PER;

   always_ff @(posedge clk) begin
      if (!rst_n)       idle_q <= '0;
      else if (grant_i) idle_q <= base + span;
   end

   assign busy_o      = now_i < idle_q;
   assign next_idle_o = idle_q;

   occ_free_sched u_free (
      .clk    (clk),
      .rst_n  (rst_n),
      .grant_i(grant_i),
      .busy_i (busy_o),
      .free_o (free_o)
   );

   assert_idle_monotonic_R7: assert property (@(posedge clk) disable iff (!rst_n)
      grant_i |=> idle_q >= $past(idle_q))
      else $error("idle time moved backwards");

   assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !grant_i |=> $stable(idle_q))
      else $error("idle time changed without a grant");

   assert_idle_after_now_R6: assert property (@(posedge clk) disable iff (!rst_n)
      grant_i |=> idle_q >= $past(now_i))
      else $error("idle time set before grant time");

   assert_req_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_i && is_req_i) |-> cycles == SIZE_W'(1))
      else $error("request span not one cycle");

endmodule

// File: tb/tb_occ_bus_tracker.sv
module tb_occ_bus_tracker;
   localparam int CLK_PERIOD = 10;
   localparam int TW = 16;
   localparam int SW = 8;
   localparam int BB = 8;
   localparam int PT = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          grant_i = 1'b0;
   logic          is_req_i = 1'b0;
   logic          is_resp_i = 1'b0;
   logic          has_data_i = 1'b0;
   logic [SW-1:0] size_i = '0;
   logic [TW-1:0] now_i = '0;
   logic          busy_o;
   logic [TW-1:0] next_idle_o;
   logic          free_o;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   int    exp_q[$];
   string tag_q[$];
   int    drv_next = 0;
   int    m_cur = 0;
   bit    m_pend = 1'b0;
   logic  gnt_seen = 1'b0;

   occ_bus_tracker #(.TIME_W(TW), .SIZE_W(SW), .BEAT_BYTES(BB), .CLK_TICKS(PT)) dut (
      .clk(clk), .rst_n(rst_n), .grant_i(grant_i), .is_req_i(is_req_i),
      .is_resp_i(is_resp_i), .has_data_i(has_data_i), .size_i(size_i),
      .now_i(now_i), .busy_o(busy_o), .next_idle_o(next_idle_o), .free_o(free_o));

   always #(CLK_PERIOD/2) clk = ~clk;

   // Time advances just after each rising edge, one tick per clock.
   always @(posedge clk) begin
      #2;
      if (rst_n) now_i <= now_i + 1'b1;
   end

   always @(posedge clk) gnt_seen <= rst_n & grant_i;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at t=%0d", tag, act, exp, now_i);
      end
   endtask

   function automatic int span_of(input bit req, input bit resp, input bit dat,
                                  input int size);
      int c;
      c = 0;
      if (req) c = 1;
      else if (dat) begin
         for (int s = 0; s < size; s += BB) c++;
         if (c == 0) c = 1;
      end else if (resp) c = 1;
      return c;
   endfunction

   // Driver: presents a grant and pushes the expected idle time.
   task automatic send(input bit req, input bit resp, input bit dat, input int size,
                       input string tag);
      int e;
      @(negedge clk);
      grant_i = 1'b1; is_req_i = req; is_resp_i = resp; has_data_i = dat;
      size_i = SW'(size);
      e = drv_next;
      while (e < int'(now_i)) e += PT;
      e += span_of(req, resp, dat, size) * PT;
      drv_next = e;
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         grant_i = 1'b0; is_req_i = 1'b0; is_resp_i = 1'b0; has_data_i = 1'b0;
      end
   endtask

   // Monitor: scoreboard pop after each grant, plus per-cycle busy/free checks.
   always @(negedge clk) begin
      #1;
      if (rst_n && !done) begin
         if (gnt_seen) begin
            if (exp_q.size() == 0) check(1'b0, "R7 unexpected update", int'(next_idle_o), m_cur);
            else begin
               int    e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(int'(next_idle_o) == e, t, int'(next_idle_o), e);
               m_cur = e;
               m_pend = 1'b1;
            end
         end else begin
            check(int'(next_idle_o) == m_cur, "R7 hold", int'(next_idle_o), m_cur);
         end
         check(busy_o == (int'(now_i) < m_cur), "R8 busy", int'(busy_o),
               int'(int'(now_i) < m_cur));
         begin
            bit ef;
            ef = m_pend && (int'(now_i) >= m_cur) && !grant_i;
            check(free_o == ef, "R9 free pulse", int'(free_o), int'(ef));
            if (ef) m_pend = 1'b0;
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(next_idle_o == '0, "R1 idle after reset", int'(next_idle_o), 0);
      check(busy_o == 1'b0, "R1 busy after reset", int'(busy_o), 0);
      check(free_o == 1'b0, "R1 free after reset", int'(free_o), 0);
      rst_n = 1'b1;
      idle(2);
      send(1, 0, 0, 0, "R2 request");                  idle(6);
      send(0, 0, 1, 20, "R3 data 20B");                idle(14);
      send(0, 1, 1, 16, "R3 data 16B");                idle(10);
      send(0, 0, 1, 9, "R3 data 9B");                  idle(10);
      send(0, 0, 1, 0, "R4 zero-byte data");           idle(6);
      send(0, 1, 0, 0, "R5 dataless response");        idle(6);
      send(0, 0, 0, 5, "R5 no flags");                 idle(3);
      send(1, 1, 1, 64, "R2 request with data");       idle(6);
      // R9: back-to-back grants move the pending pulse
      send(0, 0, 1, 24, "R9 first of pair");
      send(1, 0, 0, 0, "R9 second of pair");           idle(20);
      // R6: grant exactly on a boundary
      while ((int'(now_i) + 1) % PT != 0) idle(1);
      send(1, 0, 0, 0, "R6 on boundary");              idle(8);
      // R6: grant one tick past a boundary
      while ((int'(now_i) + 1) % PT != 1) idle(1);
      send(0, 1, 0, 0, "R6 past boundary");            idle(8);
      // R9: grant in the cycle the pulse would fire
      send(1, 0, 0, 0, "R9 arm");
      while (int'(now_i) + 1 < drv_next) idle(1);
      send(0, 0, 1, 17, "R9 grant at idle time");      idle(16);
      // R6: stored idle time still ahead of now is kept
      send(0, 0, 1, 40, "R7 long burst");
      idle(3);
      send(0, 0, 1, 8, "R6 keep future idle");         idle(40);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule